// File: doc/BRIEF.md
# Drive Step and Head Timer

This block generates the timing for one floppy-style drive mechanism from three programmed intervals: a step rate, a head-unload delay and a head-load settle delay. A parameter-load strobe captures all three at once, along with a transfer-mode bit. A two-bit data-rate select stretches or shrinks every interval. The drive encoding does not change the intervals.

A seek request carries a step count and a direction. The block answers with that many step pulses and holds the direction level steady while they run. The first pulse comes after half a step interval and each later pulse after a full interval. A one-cycle seek-done pulse closes the sequence. A read/write start loads the head and, after the settle delay, raises a flag saying the operation may begin. A read/write end starts the unload countdown. A new start during that countdown keeps the head loaded and skips the settle delay.

Each interval is counted in ticks from a per-sequencer prescaler. A tick stands for a nominal 0.5 ms at 500 kbit/s. The prescaler is restarted whenever an interval is loaded, so every delay is an exact number of clock cycles.

Step sequencer states: `SK_IDLE` (accepts a request), `SK_WAIT` (counts down to the next pulse), `SK_PULSE` (step output high), `SK_DONE` (seek-done pulse). Its transitions are:
- IDLE→WAIT on a request with a non-zero count.
- IDLE→DONE on a request with a zero count.
- WAIT→PULSE when the interval expires.
- PULSE→WAIT when steps remain.
- PULSE→DONE after the last step.
- DONE→IDLE always.

Head controller states: `HD_OFF`, `HD_SETTLE`, `HD_READY`, `HD_HOLD`. Its transitions are:
- OFF→SETTLE on start.
- SETTLE→READY when the load delay expires.
- READY→HOLD on end.
- HOLD→READY on start (cancel).
- HOLD→OFF when the unload delay expires.

Top module: `drive_step_head_timer`

## Requirements
- R1: A cycle with `spec_we` high stores `spec_srt`, `spec_hut` and `spec_hlt`. The next interval that starts uses the new values.
- R2: `spec_nd` has no effect: `dma_mode_o` stays 1 after any parameter load, including one with `spec_nd`=1.
- R3: One tick lasts UNIT_CYC×F clock cycles. F is 10, 16, 20 and 5 for `rate_sel` 00 (500k), 01 (300k), 10 (250k) and 11 (1M).
- R4: The first step rises (16−SRT) ticks after the cycle that accepts a seek. Each later step rises 2×(16−SRT) ticks after the previous rise.
- R5: Each step pulse is high for exactly STEP_W cycles. Exactly `seek_count` pulses are issued. `dir_o` equals the `seek_dir` captured at acceptance.
- R6: `seek_done_o` is high for one cycle, in the cycle right after the last step falls. With a count of 0 it is high in the cycle after acceptance and no step is issued.
- R7: A seek request made while a seek is running is ignored: the step count of the running seek is unchanged.
- R8: A read/write start with the head unloaded raises `head_load_o` in the next cycle. `op_ready_o` follows 4×HLT ticks later, or 512 ticks when HLT=0.
- R9: A read/write end with the head ready drops `op_ready_o` in the next cycle. `head_load_o` falls 32×HUT ticks later, or 512 ticks when HUT=0.
- R10: A read/write start during the unload countdown raises `op_ready_o` in the next cycle, with no settle delay and without dropping `head_load_o`.
- R11: After reset `step_o`, `seek_done_o`, `head_load_o` and `op_ready_o` are 0 and `dma_mode_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spec_we | input | 1 | Parameter load strobe |
| spec_srt | input | 4 | Step rate field |
| spec_hut | input | 4 | Head unload field |
| spec_hlt | input | 7 | Head load field |
| spec_nd | input | 1 | Transfer-mode bit (ignored) |
| rate_sel | input | 2 | Data-rate select |
| seek_req | input | 1 | Seek request strobe |
| seek_count | input | CNT_W | Number of steps |
| seek_dir | input | 1 | Step direction |
| rw_start | input | 1 | Read/write execution start |
| rw_end | input | 1 | Read/write execution end |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Step direction level |
| seek_done_o | output | 1 | Seek complete pulse |
| head_load_o | output | 1 | Head load |
| op_ready_o | output | 1 | Head settled, operation may start |
| dma_mode_o | output | 1 | DMA transfer mode |

## Verification
The assertions watch several properties on every cycle:
- direction stays steady during a step pulse;
- a step only rises on a prescaler tick;
- seek-done and ticks last a single cycle;
- a request made while busy leaves the remaining step count alone;
- a load never makes the head ready at once;
- unload happens only on a tick;
- a start during the unload countdown reaches ready in one cycle.

Only the bench scenarios can show the exact interval lengths for each rate and each parameter value. They also show the wrap of a zero field to 512 ticks, the pulse count, and that a new parameter load changes the next timing.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int TMR_W = 10;

    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_300K = 2'b01,
        RATE_250K = 2'b10,
        RATE_1M   = 2'b11
    } rate_e;

    typedef struct packed {
        logic [3:0] srt;
        logic [3:0] hut;
        logic [6:0] hlt;
    } spec_t;

    // Tick length multiplier in tenths of the 500k base
    function automatic logic [4:0] rate_factor(input logic [1:0] rate);
        unique case (rate_e'(rate))
            RATE_500K: return 5'd10;
            RATE_300K: return 5'd16;
            RATE_250K: return 5'd20;
            RATE_1M:   return 5'd5;
        endcase
    endfunction

    function automatic logic [TMR_W-1:0] step_half_ticks(input logic [3:0] srt);
        return TMR_W'(5'd16 - {1'b0, srt});
    endfunction

    function automatic logic [TMR_W-1:0] step_full_ticks(input logic [3:0] srt);
        return TMR_W'({(5'd16 - {1'b0, srt}), 1'b0});
    endfunction

    function automatic logic [TMR_W-1:0] load_ticks(input logic [6:0] hlt);
        return (hlt == 7'd0) ? TMR_W'(512) : TMR_W'({hlt, 2'b00});
    endfunction

    function automatic logic [TMR_W-1:0] unload_ticks(input logic [3:0] hut);
        return (hut == 4'd0) ? TMR_W'(512) : TMR_W'({hut, 5'b00000});
    endfunction

endpackage

// File: rtl/dst_tick_gen.sv
module dst_tick_gen
    import dst_pkg::*;
#(
    parameter int UNIT_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int MAXP = UNIT_CYC * 20;
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] period_m1;

    always_comb begin
        period_m1 = CW'(UNIT_CYC * int'(rate_factor(rate)) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || cnt == '0) begin
            cnt <= period_m1;
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        tick = (cnt == '0);
    end

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dst_spec_regs.sv
module dst_spec_regs
    import dst_pkg::*;
#(
    parameter bit NON_DMA_OK = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [3:0] srt,
    input  logic [3:0] hut,
    input  logic [6:0] hlt,
    input  logic       nd,
    output spec_t      spec,
    output logic       dma_mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spec     <= '0;
            dma_mode <= 1'b1;
        end else if (we) begin
            spec.srt <= srt;
            spec.hut <= hut;
            spec.hlt <= hlt;
            dma_mode <= NON_DMA_OK ? !nd : 1'b1;
        end
    end
endmodule

// File: rtl/dst_step_seq.sv
module dst_step_seq
    import dst_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [3:0]       srt,
    input  logic             seek_req,
    input  logic [CNT_W-1:0] seek_count,
    input  logic             seek_dir,
    output logic             tmr_clr,
    output logic             step_o,
    output logic             dir_o,
    output logic             seek_done_o
);
    localparam int WW = $clog2(STEP_W + 1);

    typedef enum logic [1:0] {SK_IDLE, SK_WAIT, SK_PULSE, SK_DONE} step_state_e;

    step_state_e      state, nxt;
    logic [TMR_W-1:0] timer;
    logic [CNT_W-1:0] left;
    logic [WW-1:0]    wcnt;
    logic             dir_q;
    logic             expire;

    always_comb begin
        expire  = tick && (timer == TMR_W'(1));
        nxt     = state;
        tmr_clr = 1'b0;
        unique case (state)
            SK_IDLE: begin
                if (seek_req) begin
                    tmr_clr = 1'b1;
                    nxt     = (seek_count == '0) ? SK_DONE : SK_WAIT;
                end
            end
            SK_WAIT: begin
                if (expire) begin
                    tmr_clr = 1'b1;
                    nxt     = SK_PULSE;
                end
            end
            SK_PULSE: begin
                if (wcnt == '0) begin
                    nxt = (left == '0) ? SK_DONE : SK_WAIT;
                end
            end
            SK_DONE: nxt = SK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SK_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
            left  <= '0;
            wcnt  <= '0;
            dir_q <= 1'b0;
        end else begin
            if (state == SK_IDLE && seek_req) begin
                timer <= step_half_ticks(srt);
                left  <= seek_count;
                dir_q <= seek_dir;
            end else if (state == SK_WAIT && expire) begin
                timer <= step_full_ticks(srt);
                left  <= left - CNT_W'(1);
                wcnt  <= WW'(STEP_W - 1);
            end else if (tick && timer != '0) begin
                timer <= timer - TMR_W'(1);
            end
            if (state == SK_PULSE && wcnt != '0) begin
                wcnt <= wcnt - WW'(1);
            end
        end
    end

    always_comb begin
        step_o      = (state == SK_PULSE);
        seek_done_o = (state == SK_DONE);
        dir_o       = dir_q;
    end

    // R4
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_o) |-> $past(tick));
    // R5
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && $past(step_o)) |-> $stable(dir_o));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done_o |=> !seek_done_o);
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SK_WAIT && seek_req && !expire) |=> (left == $past(left)));

endmodule

// File: rtl/dst_head_ctl.sv
module dst_head_ctl
    import dst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] hut,
    input  logic [6:0] hlt,
    input  logic       rw_start,
    input  logic       rw_end,
    output logic       tmr_clr,
    output logic       head_load_o,
    output logic       op_ready_o
);
    typedef enum logic [1:0] {HD_OFF, HD_SETTLE, HD_READY, HD_HOLD} head_state_e;

    head_state_e      state, nxt;
    logic [TMR_W-1:0] timer;
    logic             expire;

    always_comb begin
        expire  = tick && (timer == TMR_W'(1));
        nxt     = state;
        tmr_clr = 1'b0;
        unique case (state)
            HD_OFF: begin
                if (rw_start) begin
                    tmr_clr = 1'b1;
                    nxt     = HD_SETTLE;
                end
            end
            HD_SETTLE: begin
                if (expire) nxt = HD_READY;
            end
            HD_READY: begin
                if (rw_end) begin
                    tmr_clr = 1'b1;
                    nxt     = HD_HOLD;
                end
            end
            HD_HOLD: begin
                if (rw_start)    nxt = HD_READY;
                else if (expire) nxt = HD_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HD_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (state == HD_OFF && rw_start) begin
            timer <= load_ticks(hlt);
        end else if (state == HD_READY && rw_end) begin
            timer <= unload_ticks(hut);
        end else if (tick && timer != '0) begin
            timer <= timer - TMR_W'(1);
        end
    end

    always_comb begin
        head_load_o = (state != HD_OFF);
        op_ready_o  = (state == HD_READY);
    end

    // R8
    settle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(head_load_o) |-> !op_ready_o);
    // R8
    ready_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready_o |-> head_load_o);
    // R9
    unload_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(head_load_o) |-> $past(tick));
    // R10
    cancel_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HD_HOLD && rw_start) |=> (op_ready_o && head_load_o));

endmodule

// File: rtl/drive_step_head_timer.sv
module drive_step_head_timer
    import dst_pkg::*;
#(
    parameter int UNIT_CYC   = 1,
    parameter int STEP_W     = 3,
    parameter int CNT_W      = 8,
    parameter bit NON_DMA_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spec_we,
    input  logic [3:0]       spec_srt,
    input  logic [3:0]       spec_hut,
    input  logic [6:0]       spec_hlt,
    input  logic             spec_nd,
    input  logic [1:0]       rate_sel,
    input  logic             seek_req,
    input  logic [CNT_W-1:0] seek_count,
    input  logic             seek_dir,
    input  logic             rw_start,
    input  logic             rw_end,
    output logic             step_o,
    output logic             dir_o,
    output logic             seek_done_o,
    output logic             head_load_o,
    output logic             op_ready_o,
    output logic             dma_mode_o
);
    spec_t spec;
    logic  step_clr, step_tick;
    logic  head_clr, head_tick;

    dst_spec_regs #(.NON_DMA_OK(NON_DMA_OK)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(spec_we),
        .srt(spec_srt), .hut(spec_hut), .hlt(spec_hlt), .nd(spec_nd),
        .spec(spec), .dma_mode(dma_mode_o)
    );

    dst_tick_gen #(.UNIT_CYC(UNIT_CYC)) u_step_tick (
        .clk(clk), .rst_n(rst_n), .clr(step_clr), .rate(rate_sel), .tick(step_tick)
    );

    dst_tick_gen #(.UNIT_CYC(UNIT_CYC)) u_head_tick (
        .clk(clk), .rst_n(rst_n), .clr(head_clr), .rate(rate_sel), .tick(head_tick)
    );

    dst_step_seq #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_step (
        .clk(clk), .rst_n(rst_n), .tick(step_tick), .srt(spec.srt),
        .seek_req(seek_req), .seek_count(seek_count), .seek_dir(seek_dir),
        .tmr_clr(step_clr), .step_o(step_o), .dir_o(dir_o), .seek_done_o(seek_done_o)
    );

    dst_head_ctl u_head (
        .clk(clk), .rst_n(rst_n), .tick(head_tick), .hut(spec.hut), .hlt(spec.hlt),
        .rw_start(rw_start), .rw_end(rw_end), .tmr_clr(head_clr),
        .head_load_o(head_load_o), .op_ready_o(op_ready_o)
    );

    // R5: a pulse must end before the shortest interval's first tick
    initial begin
        step_width_fit_chk: assert (STEP_W >= 1 && STEP_W < UNIT_CYC * 5);
    end

endmodule

// File: tb/test_drive_step_head_timer.sv
module test_drive_step_head_timer;
    localparam int STEP_W = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spec_we = 1'b0;
    logic [3:0] spec_srt = '0;
    logic [3:0] spec_hut = '0;
    logic [6:0] spec_hlt = '0;
    logic       spec_nd = 1'b0;
    logic [1:0] rate_sel = '0;
    logic       seek_req = 1'b0;
    logic [7:0] seek_count = '0;
    logic       seek_dir = 1'b0;
    logic       rw_start = 1'b0;
    logic       rw_end = 1'b0;
    logic       step_o, dir_o, seek_done_o, head_load_o, op_ready_o, dma_mode_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // rate, srt, count, dir, first-rise delay, rise-to-rise gap (cycles, UNIT_CYC=1)
    localparam int VEC [0:5][0:5] = '{
        '{0, 12, 3, 1,  40, 80},
        '{1, 14, 2, 0,  32, 64},
        '{2, 15, 4, 1,  20, 40},
        '{3,  8, 2, 0,  40, 80},
        '{0,  0, 1, 1, 160,  0},
        '{2, 10, 0, 0,   0,  0}
    };

    drive_step_head_timer #(.UNIT_CYC(1), .STEP_W(STEP_W), .CNT_W(8)) i_drive_step_head_timer (
        .clk(clk), .rst_n(rst_n), .spec_we(spec_we), .spec_srt(spec_srt),
        .spec_hut(spec_hut), .spec_hlt(spec_hlt), .spec_nd(spec_nd),
        .rate_sel(rate_sel), .seek_req(seek_req), .seek_count(seek_count),
        .seek_dir(seek_dir), .rw_start(rw_start), .rw_end(rw_end),
        .step_o(step_o), .dir_o(dir_o), .seek_done_o(seek_done_o),
        .head_load_o(head_load_o), .op_ready_o(op_ready_o), .dma_mode_o(dma_mode_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_spec(input int srt, input int hut, input int hlt, input bit nd);
        spec_srt = 4'(srt); spec_hut = 4'(hut); spec_hlt = 7'(hlt); spec_nd = nd;
        spec_we = 1'b1;
        @(negedge clk);
        spec_we = 1'b0;
    endtask

    task automatic pulse_rw(input bit is_end);
        if (is_end) rw_end = 1'b1; else rw_start = 1'b1;
        @(negedge clk);
        rw_start = 1'b0; rw_end = 1'b0;
    endtask

    task automatic measure(input bit want_ready, input logic lvl, input int maxc, output int dt);
        dt = -1;
        for (int k = 0; k <= maxc; k++) begin
            if (k > 0) @(negedge clk);
            if ((want_ready ? op_ready_o : head_load_o) == lvl) begin
                dt = k;
                break;
            end
        end
    endtask

    task automatic run_seek(input int rate, input int srt, input int cnt, input int dir,
                            input int first, input int gap, input int retrig);
        int t0, rises, last_rise, wid, done_t;
        logic prev;
        write_spec(srt, 1, 1, 1'b0);
        rate_sel = 2'(rate);
        seek_count = 8'(cnt); seek_dir = dir[0]; seek_req = 1'b1;
        @(negedge clk);
        seek_req = 1'b0;
        t0 = cyc; rises = 0; last_rise = t0; wid = 0; done_t = -1; prev = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (k > 0) @(negedge clk);
            if (retrig >= 0 && k == retrig) begin
                seek_req = 1'b1; seek_count = 8'd5; seek_dir = ~dir[0];
            end else if (retrig >= 0 && k == retrig + 1) begin
                seek_req = 1'b0;
            end
            if (step_o) begin
                wid++;
                if (!prev) begin
                    rises++;
                    if (rises == 1) check("R1 R3 R4 first step delay", cyc - t0, first);
                    else            check("R3 R4 step spacing", cyc - last_rise, gap);
                    last_rise = cyc;
                    check("R5 direction level", int'(dir_o), dir);
                end
            end else if (prev) begin
                check("R5 pulse width", wid, STEP_W);
                wid = 0;
            end
            if (seek_done_o) begin
                done_t = cyc;
                break;
            end
            prev = step_o;
        end
        seek_req = 1'b0;
        check(retrig >= 0 ? "R7 pulse count with ignored request" : "R5 pulse count", rises, cnt);
        if (cnt == 0) check("R6 zero-count done delay", done_t - t0, 0);
        else          check("R6 done after last pulse", done_t - last_rise, STEP_W);
        @(negedge clk);
        check("R6 done single cycle", int'(seek_done_o), 0);
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int dt;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 step after reset", int'(step_o), 0);
        check("R11 done after reset", int'(seek_done_o), 0);
        check("R11 head load after reset", int'(head_load_o), 0);
        check("R11 ready after reset", int'(op_ready_o), 0);
        check("R11 dma mode after reset", int'(dma_mode_o), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            run_seek(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], -1);
        end

        // R7: second request during a running seek
        run_seek(0, 14, 2, 1, 20, 40, 10);

        // R2: mode bit set to non-DMA is ignored
        write_spec(12, 1, 3, 1'b1);
        check("R2 dma mode kept", int'(dma_mode_o), 1);

        // R8 / R9 with HLT=3, HUT=1 at 500k (10 cycles per tick)
        rate_sel = 2'b00;
        write_spec(12, 1, 3, 1'b0);
        pulse_rw(1'b0);
        check("R8 head load next cycle", int'(head_load_o), 1);
        check("R8 not ready at load", int'(op_ready_o), 0);
        measure(1'b1, 1'b1, 3000, dt);
        check("R8 settle delay", dt, 120);
        pulse_rw(1'b1);
        check("R9 ready drops", int'(op_ready_o), 0);
        check("R9 head still loaded", int'(head_load_o), 1);
        measure(1'b0, 1'b0, 3000, dt);
        check("R9 unload delay", dt, 320);

        // R8 / R9 zero fields wrap to 512 ticks at 1M (5 cycles per tick)
        rate_sel = 2'b11;
        write_spec(12, 0, 0, 1'b0);
        pulse_rw(1'b0);
        measure(1'b1, 1'b1, 3000, dt);
        check("R8 HLT=0 settle delay", dt, 2560);
        pulse_rw(1'b1);
        measure(1'b0, 1'b0, 3000, dt);
        check("R9 HUT=0 unload delay", dt, 2560);

        // R10: start during the unload countdown
        rate_sel = 2'b00;
        write_spec(12, 2, 3, 1'b0);
        pulse_rw(1'b0);
        measure(1'b1, 1'b1, 3000, dt);
        check("R8 settle before cancel", dt, 120);
        pulse_rw(1'b1);
        repeat (100) @(negedge clk);
        check("R10 head held during countdown", int'(head_load_o), 1);
        pulse_rw(1'b0);
        check("R10 ready without settle", int'(op_ready_o), 1);
        check("R10 head stays loaded", int'(head_load_o), 1);
        pulse_rw(1'b1);
        measure(1'b0, 1'b0, 3000, dt);
        check("R9 fresh unload after cancel", dt, 640);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule